// File: doc/BRIEF.md
# TDM Capture Data Memory

This block takes a group of serial time-division-multiplexed input streams and turns each 8-bit timeslot into a byte. Every stream has its own serial-to-parallel shifter. One shared bit and channel counter is aligned by a frame pulse. When a channel's eighth bit arrives, the byte for every stream is written into a data memory. The memory is indexed by stream and channel. Channels are written in order, and each new frame overwrites the one before it.

A host port reads the memory back. Bit 14 of the host address picks memory space over register space. A 3-bit memory-select value, taken from a control register outside this block, must equal this memory's code. Bits 13:9 of the address give the stream and bits 8:0 give the channel. Read data is 16 bits wide. The upper byte is always zero and the lower byte holds the captured timeslot.

The first bit received in each timeslot is always stored in byte bit 7. This holds under either wire convention. The bus that sends the data its MSB first and the bus that sends it LSB first both store the same way, so software undoes the convention when it reads. The full-rate configuration uses 16 streams with 512 channels each (`CHANNELS = 512`). The default is smaller so that elaboration stays light.

Top module: `tdm_capture_mem`

## Requirements
- R1: After reset, `cpu_rdata` is 0 and every memory location reads back as 8'h00.
- R2: No byte is captured until the first `frame_pulse` has been seen.
- R3: Each channel spans 8 clock cycles, one bit per cycle. The first bit of a channel is stored in bit 7 and the last bit in bit 0.
- R4: A read is a cycle with `cpu_req`=1, `cpu_we`=0, `cpu_addr[14]`=1 and `mem_sel`=`SEL_CODE`. The stream number is `cpu_addr[13:9]` and the channel number is `cpu_addr[8:0]`. The stored byte appears on `cpu_rdata` in the following cycle.
- R5: If `mem_sel` differs from `SEL_CODE` (default 3'd1), the access returns 0 in the next cycle.
- R6: If `cpu_addr[14]`=0 (register space), the access returns 0 in the next cycle.
- R7: `cpu_rdata[15:8]` is always zero.
- R8: A read of a stream at or above `NUM_STREAMS`, or of a channel at or above `CHANNELS`, returns 0.
- R9: Host writes (`cpu_req`=1, `cpu_we`=1) leave the memory unchanged and return 0 in the next cycle.
- R10: If a read and a capture write hit the same location on the same edge, the read returns the byte from before the write.
- R11: Every frame overwrites each location in channel order, so a read returns the byte from the latest completed timeslot.
- R12: In a cycle that follows a cycle without `cpu_req`, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | High during bit 0 of channel 0 |
| ser_in | input | NUM_STREAMS | Serial data, one line per stream |
| cpu_req | input | 1 | Host access strobe |
| cpu_we | input | 1 | Host write flag (writes are discarded) |
| cpu_addr | input | 15 | Host address: space bit, stream, channel |
| mem_sel | input | 3 | Memory-select field from the control register |
| cpu_rdata | output | 16 | Registered read data |

## Verification
The bound checks for the host side assume only that `cpu_req`, `cpu_we`, `cpu_addr` and `mem_sel` are stable around each clock edge. The bench guarantees this by driving them a fixed delay after the falling edge. The capture side assumes `frame_pulse` is a single-cycle pulse that repeats exactly once per frame of `CHANNELS`×8 cycles, with serial bits changing only between rising edges. The bench's frame driver generates exactly that framing. It also holds a frame's contents constant from frame to frame until a test asks for a new pattern, so reads see settled memory except in the one deliberate collision test.

// File: rtl/tdm_capture_mem.sv
module tdm_capture_mem #(
  parameter int         NUM_STREAMS = 16,
  parameter int         CHANNELS    = 128,
  parameter logic [2:0] SEL_CODE    = 3'd1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_pulse,
  input  logic [NUM_STREAMS-1:0] ser_in,
  input  logic                   cpu_req,
  input  logic                   cpu_we,
  input  logic [14:0]            cpu_addr,
  input  logic [2:0]             mem_sel,
  output logic [15:0]            cpu_rdata
);
  localparam int DEPTH = NUM_STREAMS * CHANNELS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  logic [7:0]    mem [DEPTH];
  logic [6:0]    shreg [NUM_STREAMS];
  logic [2:0]    bit_cnt;
  logic [CW-1:0] chan_cnt;
  logic          synced;

  logic [2:0]    cur_bit;
  logic [CW-1:0] cur_chan;
  logic          byte_done;

  assign cur_bit   = frame_pulse ? 3'd0 : bit_cnt;
  assign cur_chan  = frame_pulse ? '0 : chan_cnt;
  assign byte_done = synced && !frame_pulse && (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= 3'd0;
      chan_cnt <= '0;
      synced   <= 1'b0;
    end else begin
      synced  <= synced | frame_pulse;
      bit_cnt <= cur_bit + 3'd1;
      if (cur_bit == 3'd7)
        chan_cnt <= (cur_chan == CW'(CHANNELS - 1)) ? '0 : cur_chan + 1'b1;
      else
        chan_cnt <= cur_chan;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      for (int s = 0; s < NUM_STREAMS; s++) shreg[s] <= 7'h00;
    end else begin
      for (int s = 0; s < NUM_STREAMS; s++) begin
        shreg[s] <= {shreg[s][5:0], ser_in[s]};
        if (byte_done)
          mem[AW'(s * CHANNELS + int'(chan_cnt))] <= {shreg[s], ser_in[s]};
      end
    end
  end

  logic [4:0]    rd_stream;
  logic [8:0]    rd_chan;
  logic          rd_hit;
  logic [AW-1:0] rd_idx;

  assign rd_stream = cpu_addr[13:9];
  assign rd_chan   = cpu_addr[8:0];
  assign rd_hit    = cpu_req && !cpu_we && cpu_addr[14] && (mem_sel == SEL_CODE) &&
                     (int'(rd_stream) < NUM_STREAMS) && (int'(rd_chan) < CHANNELS);
  assign rd_idx    = AW'(int'(rd_stream) * CHANNELS + int'(rd_chan));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cpu_rdata <= 16'h0000;
    else
      cpu_rdata <= rd_hit ? {8'h00, mem[rd_idx]} : 16'h0000;
  end
endmodule

// File: rtl/tdm_capture_mem_chk.sv
module tdm_capture_mem_chk #(
  parameter logic [2:0] SEL_CODE = 3'd1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic [14:0] cpu_addr,
  input logic [2:0]  mem_sel,
  input logic [15:0] cpu_rdata
);
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[15:8] == 8'h00);

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |=> cpu_rdata == 16'h0000);

  // R6
  reg_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_addr[14]) |=> cpu_rdata == 16'h0000);

  // R5
  sel_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && mem_sel != SEL_CODE) |=> cpu_rdata == 16'h0000);

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we) |=> cpu_rdata == 16'h0000);
endmodule

bind tdm_capture_mem tdm_capture_mem_chk #(.SEL_CODE(SEL_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .mem_sel(mem_sel), .cpu_rdata(cpu_rdata)
);

// File: tb/tdm_capture_mem_bench.sv
`timescale 1ns/1ps
module tdm_capture_mem_bench;
  localparam int NS = 4;
  localparam int CH = 4;
  localparam int FRAME = CH * 8;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_pulse = 1'b0;
  logic [NS-1:0] ser_in = '0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [14:0]   cpu_addr = '0;
  logic [2:0]    mem_sel = 3'd1;
  logic [15:0]   cpu_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  bit pulse_en = 0;
  int next_fid = 0;
  int drv_fid = 0, drv_chan = 0, drv_bit = 0;

  always #2.5 clk = ~clk;

  tdm_capture_mem #(.NUM_STREAMS(NS), .CHANNELS(CH), .SEL_CODE(3'd1)) u_tdm_capture_mem (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .mem_sel(mem_sel),
    .cpu_rdata(cpu_rdata)
  );

  function automatic logic [7:0] pat(int s, int c, int f);
    return 8'((s * 53 + c * 29 + f * 97 + 60) & 255);
  endfunction

  function automatic logic [14:0] mk(bit space, int s, int c);
    return {space, 5'(s), 9'(c)};
  endfunction

  function automatic logic [15:0] model(logic we, logic [2:0] sel, logic [14:0] a, int f);
    int s = int'(a[13:9]);
    int c = int'(a[8:0]);
    if (!we && sel == 3'd1 && a[14] && s < NS && c < CH) return {8'h00, pat(s, c, f)};
    return 16'h0000;
  endfunction

  function automatic string tag_name(int t);
    case (t)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // {tag[3:0], we, sel[2:0], space, stream[4:0], chan[8:0]}
  localparam logic [22:0] VECS [NV] = '{
    {4'd3, 1'b0, 3'd1, 1'b1, 5'd0, 9'd0},
    {4'd4, 1'b0, 3'd1, 1'b1, 5'd3, 9'd3},
    {4'd3, 1'b0, 3'd1, 1'b1, 5'd2, 9'd1},
    {4'd4, 1'b0, 3'd1, 1'b1, 5'd1, 9'd2},
    {4'd5, 1'b0, 3'd2, 1'b1, 5'd1, 9'd2},
    {4'd5, 1'b0, 3'd0, 1'b1, 5'd0, 9'd0},
    {4'd6, 1'b0, 3'd1, 1'b0, 5'd1, 9'd1},
    {4'd8, 1'b0, 3'd1, 1'b1, 5'd4, 9'd0},
    {4'd8, 1'b0, 3'd1, 1'b1, 5'd0, 9'd4},
    {4'd9, 1'b1, 3'd1, 1'b1, 5'd2, 9'd2}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host(input logic we, input logic [2:0] sel, input logic [14:0] a,
                      output logic [15:0] got);
    cpu_req = 1'b1; cpu_we = we; mem_sel = sel; cpu_addr = a;
    @(negedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
    got = cpu_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin : driver
    logic [7:0] b8;
    int fid;
    forever begin
      fid = next_fid;
      for (int c = 0; c < CH; c++) begin
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          frame_pulse = pulse_en && c == 0 && b == 0;
          drv_fid = fid; drv_chan = c; drv_bit = b;
          for (int s = 0; s < NS; s++) begin
            b8 = pat(s, c, fid);
            ser_in[s] = b8[7 - b];
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] got;
    logic [22:0] v;
    cycles(4);
    rst_n = 1'b1;
    cycles(1);
    check("R1 rdata after reset", cpu_rdata, 16'h0000);
    host(1'b0, 3'd1, mk(1, 0, 0), got);
    check("R1 location after reset", got, 16'h0000);

    cycles(2 * FRAME + 3);
    host(1'b0, 3'd1, mk(1, 1, 2), got);
    check("R2 no capture before frame pulse", got, 16'h0000);

    pulse_en = 1;
    cycles(3 * FRAME);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      host(v[18], v[17:15], v[14:0], got);
      check(tag_name(int'(v[22:19])), got, model(v[18], v[17:15], v[14:0], 0));
      check("R7 upper byte", {got[15:8], 8'h00}, 16'h0000);
    end

    host(1'b0, 3'd1, mk(1, 2, 2), got);
    check("R9 write left location unchanged", got, {8'h00, pat(2, 2, 0)});
    cycles(1);
    check("R12 idle cycle reads zero", cpu_rdata, 16'h0000);

    next_fid = 1;
    cycles(3 * FRAME);
    host(1'b0, 3'd1, mk(1, 1, 3), got);
    check("R11 new frame overwrites", got, {8'h00, pat(1, 3, 1)});
    host(1'b0, 3'd1, mk(1, 3, 0), got);
    check("R11 new frame channel 0", got, {8'h00, pat(3, 0, 1)});

    next_fid = 2;
    while (!(drv_fid == 2 && drv_chan == 2 && drv_bit == 7)) cycles(1);
    host(1'b0, 3'd1, mk(1, 1, 2), got);
    check("R10 collision returns old byte", got, {8'h00, pat(1, 2, 1)});
    host(1'b0, 3'd1, mk(1, 1, 2), got);
    check("R10 byte after collision write", got, {8'h00, pat(1, 2, 2)});

    pulse_en = 0;
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(FRAME + 1);
    host(1'b0, 3'd1, mk(1, 0, 0), got);
    check("R1 memory cleared by reset", got, 16'h0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule